// File: doc/BRIEF.md
# Saturating Seconds Clock with Watchdog

This block keeps elapsed time in whole seconds and also supervises software through a watchdog. A 32.768 kHz clock-enable input drives a fixed binary prescaler. The prescaler issues one tick per second, and each tick advances a 24-bit seconds count. That range covers roughly 194 days. The count does not wrap. Once every bit is set, it stays there until software clears it.

Software reaches the block through a small register bus with an address, write and read strobes, and byte-wide data. The count is read as three bytes. A read of the low byte also captures the middle and high bytes, so the two reads that follow return values from the same instant.

The watchdog counts the same 32.768 kHz enable. If software does not write the service address for 2^16 enables (exactly two seconds), the block emits a one-cycle reset-request pulse and the watchdog starts counting again. While the power-down input is high:
- the seconds count keeps running;
- bus reads return zero and bus writes are dropped;
- the watchdog holds its count.

Register addresses:
- 0: low count byte. Reading it also captures the middle and high bytes.
- 1: captured middle byte.
- 2: captured high byte.
- 3: clear the clock. Any write zeroes both the count and the prescaler.
- 4: service the watchdog. Any write restarts it.
- 5: configuration, readable and writable. Bit 0 set disables the watchdog.

Any other address reads 0x00.

Top module: `rtc_wdog_top`

## Requirements
- R1: After system reset, the count, the captured bytes, the configuration byte and bus_rdata are all 0, and reset_req is low.
- R2: The seconds count advances by exactly one on the 2^PRESCALE_W-th asserted tick_32k after a clear (32768 by default).
- R3: Once the count reaches all ones (2^COUNT_W-1), further seconds leave it unchanged.
- R4: Reading address 0 returns the live low byte and captures the middle and high bytes. Addresses 1 and 2 return those captured bytes, which hold until the next read of address 0.
- R5: Any write to address 3 sets both the count and the prescaler phase to zero. The next second therefore takes a full 2^PRESCALE_W ticks.
- R6: While pwr_down is high, the count keeps advancing, every read returns 0x00, and writes to addresses 3, 4 and 5 have no effect.
- R7: With no service write, reset_req pulses high for exactly one cycle. The pulse appears on the clock edge that follows the 2^WDOG_W-th counted tick. Counting then restarts from zero, so the pulses repeat every 2^WDOG_W ticks.
- R8: Any write to address 4 restarts the watchdog from zero. When that write falls in the same cycle as the tick that would expire the watchdog, the write wins and no pulse is emitted.
- R9: With bit 0 of address 5 set, the watchdog is held at zero and never pulses; the byte reads back as written. While pwr_down is high, the watchdog holds its count and resumes from it afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, clears everything |
| tick_32k | input | 1 | 32.768 kHz clock enable, one cycle wide |
| pwr_down | input | 1 | Power-down state: blocks the bus, freezes the watchdog |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; bus_rdata is valid on the next cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
Two events can land in the same cycle: a service write and the enable tick that would expire the watchdog. The bench brings the watchdog to its last count, then issues the service write with tick_32k held high in that same cycle. It passes only if no pulse appears and the next pulse comes a full window later. The same approach is used for the clear write and the prescaler phase. The bench clears part-way through a second and then confirms that the next second still takes a full prescaler period.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int SEC_BUS_W = 24;
  localparam logic [ADDR_W-1:0] A_SEC_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] A_SEC_MID = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEC_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLK_CLR = 3'd3;
  localparam logic [ADDR_W-1:0] A_WD_SVC  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CONFIG  = 3'd5;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic clear,
  output logic sec_tick
);
  logic [PRESCALE_W-1:0] phase_q;

  function automatic logic [PRESCALE_W-1:0] phase_next(input logic [PRESCALE_W-1:0] p,
                                                       input logic t, input logic c);
    if (c) return '0;
    return t ? p + 1'b1 : p;
  endfunction

  assign sec_tick = tick_in & (&phase_q) & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_next(phase_q, tick_in, clear);
  end
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int COUNT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  output logic [COUNT_W-1:0] count
);
  localparam logic [COUNT_W-1:0] TOP = '1;

  function automatic logic [COUNT_W-1:0] sat_step(input logic [COUNT_W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (step)  count <= sat_step(count);
  end
endmodule

// File: rtl/rtc_watchdog.sv
module rtc_watchdog #(
  parameter int WDOG_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic service,
  input  logic disable_wd,
  input  logic freeze,
  output logic expire,
  output logic reset_req
);
  logic [WDOG_W-1:0] wd_q;
  logic              run;

  function automatic logic [WDOG_W-1:0] wd_next(input logic [WDOG_W-1:0] w,
                                                input logic restart, input logic adv);
    if (restart) return '0;
    return adv ? w + 1'b1 : w;
  endfunction

  assign run    = ~freeze & ~disable_wd;
  assign expire = run & tick_in & (&wd_q) & ~service;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q      <= '0;
      reset_req <= 1'b0;
    end else begin
      wd_q      <= wd_next(wd_q, service | disable_wd, run & tick_in);
      reset_req <= expire;
    end
  end
endmodule

// File: rtl/rtc_wdog_top.sv
module rtc_wdog_top
  import rtc_pkg::*;
#(
  parameter int PRESCALE_W = 15,
  parameter int COUNT_W    = 24,
  parameter int WDOG_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_32k,
  input  logic              pwr_down,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);
  logic                 wr_ok, rd_ok;
  logic                 clk_clear_w, wd_service_w, cfg_wr_w, snap_w;
  logic                 sec_tick_w, wd_expire_w;
  logic [COUNT_W-1:0]   count_w;
  logic [SEC_BUS_W-1:0] sec_count_w;
  logic [DATA_W-1:0]    cfg_q, snap_mid_q, snap_hi_q, rd_mux;
  logic                 cfg_dis_w;

  assign wr_ok        = bus_wr & ~pwr_down;
  assign rd_ok        = bus_rd & ~pwr_down;
  assign clk_clear_w  = wr_ok & (bus_addr == A_CLK_CLR);
  assign wd_service_w = wr_ok & (bus_addr == A_WD_SVC);
  assign cfg_wr_w     = wr_ok & (bus_addr == A_CONFIG);
  assign snap_w       = rd_ok & (bus_addr == A_SEC_LO);
  assign cfg_dis_w    = cfg_q[0];

  always_comb begin
    sec_count_w = '0;
    sec_count_w[COUNT_W-1:0] = count_w;
  end

  rtc_prescaler #(.PRESCALE_W(PRESCALE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_32k), .clear(clk_clear_w), .sec_tick(sec_tick_w)
  );

  rtc_sec_counter #(.COUNT_W(COUNT_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .clear(clk_clear_w), .step(sec_tick_w), .count(count_w)
  );

  rtc_watchdog #(.WDOG_W(WDOG_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_32k), .service(wd_service_w),
    .disable_wd(cfg_dis_w), .freeze(pwr_down), .expire(wd_expire_w), .reset_req(reset_req)
  );

  always_comb begin
    case (bus_addr)
      A_SEC_LO:  rd_mux = sec_count_w[7:0];
      A_SEC_MID: rd_mux = snap_mid_q;
      A_SEC_HI:  rd_mux = snap_hi_q;
      A_CONFIG:  rd_mux = cfg_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      snap_mid_q <= '0;
      snap_hi_q  <= '0;
      bus_rdata  <= '0;
    end else begin
      if (cfg_wr_w) cfg_q <= bus_wdata;
      if (snap_w) begin
        snap_mid_q <= sec_count_w[15:8];
        snap_hi_q  <= sec_count_w[23:16];
      end
      if (rd_ok)       bus_rdata <= rd_mux;
      else if (bus_rd) bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/rtc_wdog_chk.sv
module rtc_wdog_chk #(
  parameter int COUNT_W = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_down,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_rdata,
  input logic        reset_req,
  input logic [23:0] sec_count,
  input logic        sec_tick,
  input logic        clk_clear,
  input logic        wd_service,
  input logic [7:0]  cfg
);
  localparam logic [23:0] CNT_MAX = 24'((64'(1) << COUNT_W) - 1);

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !clk_clear && sec_count != CNT_MAX) |=> sec_count == $past(sec_count) + 24'd1);

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_count == CNT_MAX && !clk_clear) |=> sec_count == CNT_MAX);

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_clear |=> sec_count == 24'd0);

  // R6
  pd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && bus_rd) |=> bus_rdata == 8'd0);

  // R6
  pd_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && bus_wr) |=> $stable(cfg));

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R8
  svc_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_service |=> !reset_req);

  // R9
  pd_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !reset_req);
endmodule

bind rtc_wdog_top rtc_wdog_chk #(.COUNT_W(COUNT_W)) u_rtc_wdog_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .reset_req(reset_req), .sec_count(sec_count_w),
  .sec_tick(sec_tick_w), .clk_clear(clk_clear_w), .wd_service(wd_service_w), .cfg(cfg_q)
);

// File: tb/test_rtc_wdog_top.sv
module test_rtc_wdog_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic       pwr_down = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] rdata_m, rdata_s;
  logic       req_m, req_s;
  int         n_chk = 0;
  int         n_bad = 0;
  int         pulses_m = 0;
  int         pulses_s = 0;
  int         cycles = 0;

  always #10 clk = ~clk;

  rtc_wdog_top i_rtc_wdog_top (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .pwr_down(pwr_down),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_m), .reset_req(req_m)
  );

  rtc_wdog_top #(.PRESCALE_W(1), .COUNT_W(10), .WDOG_W(4)) i_rtc_wdog_top_small (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .pwr_down(pwr_down),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_s), .reset_req(req_s)
  );

  always @(posedge clk) begin
    if (req_m) pulses_m <= pulses_m + 1;
    if (req_s) pulses_s <= pulses_s + 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got %0d cycles exp fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk) tick_32k = 1'b1;
    repeat (n) @(negedge clk);
    tick_32k = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic t);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_32k = t;
    @(negedge clk);
    bus_wr = 1'b0; tick_32k = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rd(3'd0); check("R1 lo", rdata_m, 0);
    rd(3'd1); check("R1 mid", rdata_m, 0);
    rd(3'd2); check("R1 hi", rdata_m, 0);
    rd(3'd5); check("R1 cfg", rdata_m, 0);
    check("R1 req", req_m, 0);
  endtask

  task automatic t_prescale();
    wr(3'd3, 8'h00, 1'b0);
    ticks(32767);
    rd(3'd0); check("R2 before", rdata_m, 0);
    ticks(1);
    rd(3'd0); check("R2 after", rdata_m, 1);
  endtask

  task automatic t_saturate();
    wr(3'd3, 8'h00, 1'b0);
    ticks(2046);
    rd(3'd0); check("R3 lo max", rdata_s, 8'hFF);
    rd(3'd1); check("R3 mid max", rdata_s, 8'h03);
    ticks(10);
    rd(3'd0); check("R3 lo held", rdata_s, 8'hFF);
    rd(3'd1); check("R3 mid held", rdata_s, 8'h03);
  endtask

  task automatic t_snapshot();
    wr(3'd3, 8'h00, 1'b0);
    ticks(600);
    rd(3'd0); check("R4 lo", rdata_s, 8'h2C);
    rd(3'd1); check("R4 mid", rdata_s, 8'h01);
    rd(3'd2); check("R4 hi", rdata_s, 8'h00);
    ticks(600);
    rd(3'd1); check("R4 mid held", rdata_s, 8'h01);
    rd(3'd0); check("R4 lo new", rdata_s, 8'h58);
    rd(3'd1); check("R4 mid new", rdata_s, 8'h02);
  endtask

  task automatic t_clear();
    wr(3'd3, 8'h00, 1'b0);
    ticks(5);
    rd(3'd0); check("R5 pre", rdata_s, 2);
    wr(3'd3, 8'h00, 1'b0);
    ticks(1);
    rd(3'd0); check("R5 phase reset", rdata_s, 0);
    ticks(1);
    rd(3'd0); check("R5 full period", rdata_s, 1);
  endtask

  task automatic t_powerdown();
    wr(3'd3, 8'h00, 1'b0);
    @(negedge clk) pwr_down = 1'b1;
    ticks(20);
    wr(3'd3, 8'h00, 1'b0);
    wr(3'd5, 8'h01, 1'b0);
    rd(3'd0); check("R6 read blocked small", rdata_s, 0);
    check("R6 read blocked main", rdata_m, 0);
    @(negedge clk) pwr_down = 1'b0;
    rd(3'd0); check("R6 kept counting", rdata_s, 10);
    rd(3'd5); check("R6 cfg write dropped", rdata_s, 0);
  endtask

  task automatic t_wd_main();
    wr(3'd4, 8'h00, 1'b0);
    pulses_m = 0;
    ticks(65535);
    settle(); check("R7 no early pulse", pulses_m, 0);
    ticks(1);
    settle(); check("R7 pulse at 2s", pulses_m, 1);
  endtask

  task automatic t_wd_restart();
    wr(3'd4, 8'h00, 1'b0);
    pulses_s = 0;
    ticks(32);
    settle(); check("R7 repeat single pulses", pulses_s, 2);
  endtask

  task automatic t_wd_collide();
    wr(3'd4, 8'h00, 1'b0);
    pulses_s = 0;
    ticks(15);
    wr(3'd4, 8'h00, 1'b1);
    settle(); check("R8 service wins", pulses_s, 0);
    ticks(15);
    settle(); check("R8 restarted", pulses_s, 0);
    ticks(1);
    settle(); check("R8 full window", pulses_s, 1);
  endtask

  task automatic t_wd_disable();
    wr(3'd4, 8'h00, 1'b0);
    wr(3'd5, 8'h01, 1'b0);
    pulses_s = 0;
    ticks(40);
    settle(); check("R9 disabled", pulses_s, 0);
    rd(3'd5); check("R9 cfg readback", rdata_s, 1);
    wr(3'd5, 8'h00, 1'b0);
    ticks(15);
    settle(); check("R9 held at zero", pulses_s, 0);
    ticks(1);
    settle(); check("R9 enabled again", pulses_s, 1);
  endtask

  task automatic t_wd_powerdown();
    wr(3'd4, 8'h00, 1'b0);
    pulses_s = 0;
    ticks(10);
    @(negedge clk) pwr_down = 1'b1;
    ticks(100);
    @(negedge clk) pwr_down = 1'b0;
    ticks(5);
    settle(); check("R9 frozen in power-down", pulses_s, 0);
    ticks(1);
    settle(); check("R9 resumed count", pulses_s, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_saturate();
    t_snapshot();
    t_clear();
    t_powerdown();
    t_wd_restart();
    t_wd_collide();
    t_wd_disable();
    t_wd_powerdown();
    t_wd_main();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule